// File: doc/BRIEF.md
# Intra-Warp Redundant Lane Forwarding

This block lets the idle lanes of a four-lane SIMD cluster check the work of the busy lanes. When control-flow divergence switches some lanes off, the active mask at issue decides which active lane each idle lane shadows. The operand crossbar then gives every idle lane the same register operand that its partner reads, so the idle lane repeats the partner's computation on identical inputs.

When the lane results come back, tagged with the mask they were issued under, the block compares every shadow result with its partner's result. One clock later it reports a valid strobe, one mismatch flag per shadow lane, a vector of the active lanes that were checked, and a single error flag that the pipeline uses to start flush and error handling. If every lane is active, or none is, no pairs are formed and nothing can be flagged.

Top module: `lane_shadow_fwd`

## Requirements
- R1: A lane whose issue mask bit is 1 is active: its `shadow_en` bit is 0, `shadow_src` holds its own index and `fwd_opnd` carries its own operand.
- R2: When between 1 and 3 lanes are active, every inactive lane becomes a shadow (`shadow_en` = 1). Inactive lanes are taken from highest index to lowest and are dealt in turn to the active lanes, also taken from highest index to lowest. The dealing wraps to the highest active lane when the inactive lanes outnumber the active lanes. `shadow_src` gives the chosen lane's index.
- R3: A shadow lane's `fwd_opnd` equals the operand of the lane named by its `shadow_src`.
- R4: With issue mask 0000 or 1111, no lane is a shadow, every `shadow_src` is the lane's own index and every lane forwards its own operand.
- R5: `chk_valid` is 1 in the cycle after a cycle with `res_valid` = 1 and is 0 otherwise.
- R6: `pair_err[i]` is 1 in the cycle after `res_valid`, exactly when lane i is a shadow under `res_mask` (same rule as R2/R4) and its result differs from its partner's result. Otherwise it is 0.
- R7: `chk_lanes[j]` is 1 in the cycle after `res_valid`, exactly when active lane j has at least one shadow under `res_mask`. Otherwise it is 0.
- R8: `err_any` is the OR of `pair_err` in every cycle.
- R9: During synchronous active-low reset, `chk_valid`, `chk_lanes`, `pair_err` and `err_any` are 0.
- R10: With issue mask 1100, `shadow_src` from lane 3 down to lane 0 is 3, 2, 3, 2, so lane 1 receives lane 3's operand and lane 0 receives lane 2's operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_mask | input | LANES | Active mask of the instruction being issued |
| issue_opnd | input | LANES x DATA_W | Register operand read by each lane |
| fwd_opnd | output | LANES x DATA_W | Operand delivered to each lane's execution unit |
| shadow_en | output | LANES | Lane repeats another lane's work |
| shadow_src | output | LANES x IDX_W | Lane whose operand each lane uses |
| res_valid | input | 1 | Lane results are present this cycle |
| res_mask | input | LANES | Issue mask that belongs to the returning results |
| res_data | input | LANES x DATA_W | Result produced by each lane |
| chk_valid | output | 1 | Comparison outcome is valid |
| chk_lanes | output | LANES | Active lanes that had at least one shadow |
| pair_err | output | LANES | Shadow lane result differed from its partner |
| err_any | output | 1 | Any shadow pair mismatched |

## Verification
On every cycle the assertions check the structure of the pairing: an active lane is never a shadow and keeps its own operand, a shadow's partner is always an active lane, and a shadow lane's operand matches its partner's. They also check that the full and empty masks form no pairs, that the strobe trails `res_valid` by one cycle, and that error and checked-lane flags appear only under the strobe. Only the bench's scenarios can show that the dealing order is right for each of the sixteen masks, including the wrap when idle lanes outnumber busy ones. The same holds for showing that a corrupted result is flagged on exactly the right shadow lane and that a corrupted active lane blames every shadow that copies it.

// File: rtl/lane_shadow_pkg.sv
// Package: shared helpers for the redundant lane forwarding block.
// Assumes no cluster is wider than MAX_LANES lanes.
package lane_shadow_pkg;

    localparam int MAX_LANES = 32;

    // Count lanes above position pos whose mask bit equals want.
    function automatic int rank_above(
        input logic [MAX_LANES-1:0] mask,
        input int                   pos,
        input int                   lanes,
        input logic                 want
    );
        int cnt;
        cnt = 0;
        for (int k = 0; k < lanes; k++) begin
            if (k > pos && mask[k] == want) cnt++;
        end
        return cnt;
    endfunction

endpackage

// File: rtl/lane_pair_map.sv
// Module: lane_pair_map
// Derives the shadow pairing from an active mask. Inactive lanes, taken from
// the highest index down, are dealt to active lanes (highest index first),
// wrapping round the active set. A full or empty mask forms no pairs.
// Assumes LANES <= lane_shadow_pkg::MAX_LANES. Purely combinational.
module lane_pair_map #(
    parameter int LANES = 4,
    parameter int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0]            mask,
    output logic [LANES-1:0]            shadow,
    output logic [LANES-1:0][IDX_W-1:0] src
);
    import lane_shadow_pkg::*;

    logic [MAX_LANES-1:0] mask_ext;
    assign mask_ext = MAX_LANES'(mask);

    // Build the pairing: rank each idle lane, pick the active lane of the wrapped rank.
    always_comb begin : build_map
        int nact;
        int slot;
        nact = 0;
        for (int i = 0; i < LANES; i++) begin
            if (mask[i]) nact++;
        end
        for (int i = 0; i < LANES; i++) begin
            shadow[i] = 1'b0;
            src[i]    = IDX_W'(i);
            slot      = 0;
            if (!mask[i] && nact != 0 && nact != LANES) begin
                slot      = rank_above(mask_ext, i, LANES, 1'b0) % nact;
                shadow[i] = 1'b1;
                for (int j = 0; j < LANES; j++) begin
                    if (mask[j] && rank_above(mask_ext, j, LANES, 1'b1) == slot)
                        src[i] = IDX_W'(j);
                end
            end
        end
    end

endmodule

// File: rtl/lane_operand_xbar.sv
// Module: lane_operand_xbar
// Per-lane operand multiplexer: each lane takes the operand of the lane its
// source index names. Assumes src values are below LANES. Combinational.
module lane_operand_xbar #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(LANES)
) (
    input  logic [LANES-1:0][DATA_W-1:0] opnd_in,
    input  logic [LANES-1:0][IDX_W-1:0]  src,
    output logic [LANES-1:0][DATA_W-1:0] opnd_out
);
    // One selector per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane_mux
        assign opnd_out[g] = opnd_in[src[g]];
    end

endmodule

// File: rtl/lane_result_cmp.sv
// Module: lane_result_cmp
// Compares every shadow lane's result with its partner's and registers the
// outcome one cycle after the results arrive. Assumes the pairing inputs
// belong to the same cycle as the results. Synchronous active-low reset.
module lane_result_cmp #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(LANES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         valid_in,
    input  logic [LANES-1:0]             shadow,
    input  logic [LANES-1:0][IDX_W-1:0]  src,
    input  logic [LANES-1:0][DATA_W-1:0] result,
    output logic                         chk_valid,
    output logic [LANES-1:0]             chk_lanes,
    output logic [LANES-1:0]             pair_err,
    output logic                         err_any
);
    logic [LANES-1:0] miss_now;
    logic [LANES-1:0] seen_now;

    // Per-lane mismatch against the partner lane.
    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign miss_now[g] = shadow[g] && (result[g] != result[src[g]]);
    end

    // Mark every active lane that at least one shadow copies.
    always_comb begin : mark_checked
        seen_now = '0;
        for (int i = 0; i < LANES; i++) begin
            if (shadow[i]) seen_now[src[i]] = 1'b1;
        end
    end

    // Register the outcome; cleared whenever no results arrive.
    always_ff @(posedge clk) begin : hold_outcome
        if (!rst_n) begin
            chk_valid <= 1'b0;
            chk_lanes <= '0;
            pair_err  <= '0;
            err_any   <= 1'b0;
        end else begin
            chk_valid <= valid_in;
            chk_lanes <= valid_in ? seen_now : '0;
            pair_err  <= valid_in ? miss_now : '0;
            err_any   <= valid_in && (|miss_now);
        end
    end

endmodule

// File: rtl/lane_shadow_fwd.sv
// Module: lane_shadow_fwd (top)
// Redundant lane forwarding for one SIMD cluster: pairs idle lanes with
// active lanes from the issue mask, forwards operands and checks results.
// Assumes results return with the mask they were issued under.
module lane_shadow_fwd #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(LANES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES-1:0]             issue_mask,
    input  logic [LANES-1:0][DATA_W-1:0] issue_opnd,
    output logic [LANES-1:0][DATA_W-1:0] fwd_opnd,
    output logic [LANES-1:0]             shadow_en,
    output logic [LANES-1:0][IDX_W-1:0]  shadow_src,
    input  logic                         res_valid,
    input  logic [LANES-1:0]             res_mask,
    input  logic [LANES-1:0][DATA_W-1:0] res_data,
    output logic                         chk_valid,
    output logic [LANES-1:0]             chk_lanes,
    output logic [LANES-1:0]             pair_err,
    output logic                         err_any
);
    logic [LANES-1:0]            res_shadow;
    logic [LANES-1:0][IDX_W-1:0] res_src;

    // Pairing for the instruction being issued.
    lane_pair_map #(.LANES(LANES), .IDX_W(IDX_W)) u_issue_map (
        .mask   (issue_mask),
        .shadow (shadow_en),
        .src    (shadow_src)
    );

    // Operand crossbar towards the execution units.
    lane_operand_xbar #(.LANES(LANES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_xbar (
        .opnd_in  (issue_opnd),
        .src      (shadow_src),
        .opnd_out (fwd_opnd)
    );

    // Pairing recomputed for the returning results.
    lane_pair_map #(.LANES(LANES), .IDX_W(IDX_W)) u_result_map (
        .mask   (res_mask),
        .shadow (res_shadow),
        .src    (res_src)
    );

    // Result comparator and registered outcome.
    lane_result_cmp #(.LANES(LANES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (res_valid),
        .shadow    (res_shadow),
        .src       (res_src),
        .result    (res_data),
        .chk_valid (chk_valid),
        .chk_lanes (chk_lanes),
        .pair_err  (pair_err),
        .err_any   (err_any)
    );

endmodule

// File: rtl/lane_shadow_fwd_chk.sv
// Module: lane_shadow_fwd_chk
// Property checker for lane_shadow_fwd, attached by bind below.
// Assumes it sees the top module's ports unchanged.
module lane_shadow_fwd_chk #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(LANES)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [LANES-1:0]             issue_mask,
    input logic [LANES-1:0][DATA_W-1:0] issue_opnd,
    input logic [LANES-1:0][DATA_W-1:0] fwd_opnd,
    input logic [LANES-1:0]             shadow_en,
    input logic [LANES-1:0][IDX_W-1:0]  shadow_src,
    input logic                         res_valid,
    input logic [LANES-1:0]             res_mask,
    input logic [LANES-1:0][DATA_W-1:0] res_data,
    input logic                         chk_valid,
    input logic [LANES-1:0]             chk_lanes,
    input logic [LANES-1:0]             pair_err,
    input logic                         err_any
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane_props
        a_r1_active_keeps_own: assert property (@(posedge clk) disable iff (!rst_n)
            issue_mask[g] |-> (!shadow_en[g] && fwd_opnd[g] == issue_opnd[g]));
        a_r2_partner_is_active: assert property (@(posedge clk) disable iff (!rst_n)
            shadow_en[g] |-> issue_mask[shadow_src[g]]);
        a_r3_shadow_operand: assert property (@(posedge clk) disable iff (!rst_n)
            shadow_en[g] |-> fwd_opnd[g] == issue_opnd[shadow_src[g]]);
        a_r7_checked_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            chk_lanes[g] |-> chk_valid);
    end

    a_r4_no_pairs_full_or_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_mask == '0 || issue_mask == '1) |-> shadow_en == '0);
    a_r5_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> chk_valid);
    a_r5_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> !chk_valid);
    a_r6_error_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_err != '0) |-> chk_valid);
    a_r8_error_summary: assert property (@(posedge clk) disable iff (!rst_n)
        err_any == (pair_err != '0));

endmodule

bind lane_shadow_fwd lane_shadow_fwd_chk #(
    .LANES(LANES), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/lane_shadow_fwd_test.sv
// Bench: sweeps all sixteen masks for pairing and forwarding, then every
// mask against every single-lane result corruption.
module lane_shadow_fwd_test;
    localparam int L  = 4;
    localparam int W  = 32;
    localparam int IW = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [L-1:0]       issue_mask = '0;
    logic [L-1:0][W-1:0] issue_opnd = '0;
    logic [L-1:0][W-1:0] fwd_opnd;
    logic [L-1:0]       shadow_en;
    logic [L-1:0][IW-1:0] shadow_src;
    logic               res_valid = 1'b0;
    logic [L-1:0]       res_mask = '0;
    logic [L-1:0][W-1:0] res_data = '0;
    logic               chk_valid;
    logic [L-1:0]       chk_lanes;
    logic [L-1:0]       pair_err;
    logic               err_any;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;  // 50 MHz

    lane_shadow_fwd #(.LANES(L), .DATA_W(W)) uut (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Independent pairing model: list idle and busy lanes top-down, deal round-robin.
    function automatic void model(input logic [L-1:0] m, output logic [L-1:0] sh, output int srcv[L]);
        int idle[L]; int busy[L]; int ni; int na;
        ni = 0; na = 0; sh = '0;
        for (int i = L - 1; i >= 0; i--) begin
            srcv[i] = i;
            if (m[i]) begin busy[na] = i; na++; end
            else begin idle[ni] = i; ni++; end
        end
        if (na > 0 && ni > 0)
            for (int k = 0; k < ni; k++) begin
                sh[idle[k]] = 1'b1;
                srcv[idle[k]] = busy[k % na];
            end
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [L-1:0] sh;
        int srcv[L];
        logic [L-1:0][W-1:0] exp_fwd;
        logic [L-1:0] exp_err, exp_seen;

        // R9: reset state
        repeat (2) @(negedge clk);
        #1;
        check(chk_valid == 0 && err_any == 0, "R9 reset strobe/error", {chk_valid, err_any}, 0);
        check(pair_err == 0 && chk_lanes == 0, "R9 reset flags", {pair_err, chk_lanes}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Pairing and forwarding sweep (R1, R2, R3, R4)
        for (int m = 0; m < 16; m++) begin
            @(negedge clk);
            issue_mask = L'(m);
            for (int i = 0; i < L; i++) issue_opnd[i] = 32'hC0DE_0000 + 32'(m * 256 + i * 17);
            #1;
            model(issue_mask, sh, srcv);
            for (int i = 0; i < L; i++) begin
                if (issue_mask[i]) begin
                    check(!shadow_en[i] && shadow_src[i] == IW'(i) && fwd_opnd[i] == issue_opnd[i],
                          "R1 active lane keeps own", {shadow_en[i], fwd_opnd[i]}, {1'b0, issue_opnd[i]});
                end else if (m == 0) begin
                    check(!shadow_en[i] && shadow_src[i] == IW'(i) && fwd_opnd[i] == issue_opnd[i],
                          "R4 empty mask no pairs", {shadow_en[i], 6'(shadow_src[i])}, {1'b0, 6'(i)});
                end else begin
                    check(shadow_en[i] && int'(shadow_src[i]) == srcv[i], "R2 shadow partner",
                          {shadow_en[i], 6'(shadow_src[i])}, {1'b1, 6'(srcv[i])});
                    check(fwd_opnd[i] == issue_opnd[srcv[i]], "R3 shadow operand",
                          fwd_opnd[i], issue_opnd[srcv[i]]);
                end
            end
            if (m == 15) check(shadow_en == 0, "R4 full mask no pairs", shadow_en, 0);
            if (m == 12) check(shadow_src == {2'd3, 2'd2, 2'd3, 2'd2}, "R10 mask 1100 map",
                               shadow_src, {2'd3, 2'd2, 2'd3, 2'd2});
        end

        // Result check sweep: corrupt none (c=4) or one lane c (R5, R6, R7, R8)
        for (int m = 0; m < 16; m++) begin
            for (int c = 0; c < 5; c++) begin
                @(negedge clk);
                model(L'(m), sh, srcv);
                res_valid = 1'b1;
                res_mask  = L'(m);
                for (int i = 0; i < L; i++) exp_fwd[i] = 32'h1234_0000 + 32'(m * 31 + srcv[i] * 7);
                for (int i = 0; i < L; i++) res_data[i] = exp_fwd[i] * 3 + 1 ^ ((c == i) ? 32'h0000_0100 : 32'h0);
                exp_err = '0; exp_seen = '0;
                for (int i = 0; i < L; i++) begin
                    if (sh[i]) begin
                        exp_seen[srcv[i]] = 1'b1;
                        if (c == i || c == srcv[i]) exp_err[i] = 1'b1;
                    end
                end
                @(negedge clk);
                res_valid = 1'b0;
                #1;
                check(chk_valid == 1'b1, "R5 strobe after results", chk_valid, 1);
                check(pair_err == exp_err, "R6 per-pair mismatch", pair_err, exp_err);
                check(chk_lanes == exp_seen, "R7 checked lanes", chk_lanes, exp_seen);
                check(err_any == (exp_err != 0), "R8 global error", err_any, exp_err != 0);
            end
        end

        // R5/R7: quiet cycle after last results
        @(negedge clk);
        #1;
        check(chk_valid == 0 && chk_lanes == 0 && pair_err == 0, "R5 quiet without results",
              {chk_valid, chk_lanes, pair_err}, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule